// File: doc/BRIEF.md
# SPI Bus Arbiter

This block shares one SPI transaction engine among up to three attached devices. Each device has a request port that takes a descriptor handle and an operation. The operation is a transfer, a bus acquire or a bus release. Accepted requests wait in a small queue for that device. The arbiter serves the queues one transfer at a time and hands the selected handle to the engine through a request/grant/done handshake. While the transfer runs, it drives the active-low chip-select of the device that owns it.

A device can lock the bus. Once its acquire is granted, the other devices are held off until it releases the lock. While it holds the lock, the owner can ask for chip-select to stay asserted after a transfer. The select then stays active until a later transfer without that flag ends, or until the release is processed.

Some requests are illegal. The arbiter takes them off the port without queueing them and answers with a one-cycle error code. The serial shifting, data movement and pin routing stay in the engine.

Top module: `spi_bus_arbiter`

## Requirements
- R1: After reset all chip-selects are high (inactive), no engine request is raised, every port is ready, and no error or grant pulse is present.
- R2: Only one transfer is in the engine at a time, and the engine request is held until it is granted. From the engine request until done, only the chip-select of the owning device is low.
- R3: When the bus is unlocked, queued devices are served round-robin, starting with the index after the last device served; after reset device 0 has first priority.
- R4: Each device queue holds 4 entries and issues them in arrival order. When a queue is full, that port's ready goes low.
- R5: An acquire (op code 1) is granted only when the engine is idle and every earlier entry of the same device has been handled. The grant is a one-cycle pulse on that device's acquire-grant output.
- R6: While a device holds the lock, entries from all other devices are deferred until the owner's release (op code 2) is processed. A release from a device that does not own the lock has no effect.
- R7: A transfer (op code 0) with the keep-select flag set is rejected with error code 1 (invalid argument) unless the requesting device holds the lock at acceptance. The rejected request is never issued.
- R8: A transfer with the polled flag set is rejected with error code 2 (invalid state) if that device has any entry queued or in the engine. It is accepted when the device has nothing outstanding.
- R9: A keep-select transfer leaves the owner's chip-select low after done. The owner's release raises it before any other device is served.
- R10: Any outcome of a request is reported one cycle after the accepting edge: an error pulse with a nonzero code for a rejection, and no error pulse for an accepted request. A done pulse follows each completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NDEV | Per-device request valid |
| req_ready_o | output | NDEV | Per-device queue not full |
| req_op_i | input | 2*NDEV | Per-device operation: 0 transfer, 1 acquire, 2 release |
| req_handle_i | input | HW*NDEV | Per-device descriptor handle |
| req_keep_cs_i | input | NDEV | Keep chip-select active after the transfer |
| req_poll_i | input | NDEV | Polled transfer flag |
| err_valid_o | output | NDEV | One-cycle rejection pulse |
| err_code_o | output | 2*NDEV | Rejection code: 1 invalid argument, 2 invalid state |
| acq_gnt_o | output | NDEV | One-cycle lock-granted pulse |
| done_o | output | NDEV | One-cycle transfer-complete pulse |
| eng_req_o | output | 1 | Request to the transaction engine |
| eng_gnt_i | input | 1 | Engine accepts the request |
| eng_done_i | input | 1 | Engine finished the transfer |
| eng_dev_o | output | IW | Index of the device being served |
| eng_handle_o | output | HW | Handle being served |
| eng_keep_cs_o | output | 1 | Keep-select flag of the transfer being served |
| cs_n_o | output | NDEV | Active-low chip-selects |

## Verification
An error pulse is due in the cycle after the edge that accepts the request. The bench drives on a falling edge and reads the error outputs on the following falling edge, just after that accepting edge. A queued transfer reaches the engine one edge after acceptance, and an acquire grant appears one edge after the engine turns idle. The engine model therefore samples the request, the handle and the chip-selects at falling edges only. Ordering checks do not count cycles. They compare the sequence of handles the engine saw with the order the requirements predict, and use fixed idle windows to show that deferred or rejected work never reached the engine.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic [1:0] {
    OP_XFER = 2'd0,
    OP_ACQ  = 2'd1,
    OP_REL  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ARG   = 2'd1,
    ERR_STATE = 2'd2
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RUN
  } arb_st_e;
endpackage

// File: rtl/spi_arb_fifo.sv
module spi_arb_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spi_arb_rr.sv
module spi_arb_rr #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  int cand;
  logic found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    cand  = 0;
    for (int off = 1; off <= N; off++) begin
      cand = (int'(last_i) + off) % N;
      if (!found && req_i[cand]) begin
        found       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/spi_bus_arbiter.sv
module spi_bus_arbiter
  import spi_arb_pkg::*;
#(
  parameter int NDEV  = 3,
  parameter int HW    = 8,
  parameter int DEPTH = 4,
  localparam int IW   = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NDEV-1:0]   req_valid_i,
  output logic [NDEV-1:0]   req_ready_o,
  input  logic [2*NDEV-1:0] req_op_i,
  input  logic [HW*NDEV-1:0] req_handle_i,
  input  logic [NDEV-1:0]   req_keep_cs_i,
  input  logic [NDEV-1:0]   req_poll_i,
  output logic [NDEV-1:0]   err_valid_o,
  output logic [2*NDEV-1:0] err_code_o,
  output logic [NDEV-1:0]   acq_gnt_o,
  output logic [NDEV-1:0]   done_o,
  output logic              eng_req_o,
  input  logic              eng_gnt_i,
  input  logic              eng_done_i,
  output logic [IW-1:0]     eng_dev_o,
  output logic [HW-1:0]     eng_handle_o,
  output logic              eng_keep_cs_o,
  output logic [NDEV-1:0]   cs_n_o
);
  localparam int W = HW + 3;

  arb_st_e         st_q;
  logic [IW-1:0]   cur_dev_q, last_q, owner_q, pick_idx;
  logic [HW-1:0]   cur_handle_q;
  logic            cur_keep_q, lock_q, cs_hold_q;
  logic [NDEV-1:0] err_valid_q, acq_gnt_q, done_q;
  logic [2*NDEV-1:0] err_code_q;

  logic [NDEV-1:0] hs, rej_arg, rej_st, push, pop, empty, full, elig, pick_vec;
  logic [W-1:0]    head [NDEV];
  logic [W-1:0]    sel;
  op_e             sel_op;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    op_e op_in;
    assign op_in      = op_e'(req_op_i[2*g +: 2]);
    assign hs[g]      = req_valid_i[g] & req_ready_o[g];
    assign rej_arg[g] = hs[g] && op_in == OP_XFER && req_keep_cs_i[g]
                        && !(lock_q && owner_q == IW'(g));
    // outstanding = anything queued or in the engine for this device
    assign rej_st[g]  = hs[g] && op_in == OP_XFER && req_poll_i[g] && !rej_arg[g]
                        && (!empty[g] || (st_q != ST_IDLE && cur_dev_q == IW'(g)));
    assign push[g]    = hs[g] & ~rej_arg[g] & ~rej_st[g];
    assign elig[g]    = ~empty[g] & (~lock_q | (owner_q == IW'(g)));
    assign pop[g]     = (st_q == ST_IDLE) & pick_vec[g];
    assign req_ready_o[g] = ~full[g];
    assign cs_n_o[g]  = ~(((st_q != ST_IDLE) | cs_hold_q) & (cur_dev_q == IW'(g)));

    spi_arb_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push[g]),
      .data_i ({req_op_i[2*g +: 2], req_keep_cs_i[g], req_handle_i[HW*g +: HW]}),
      .pop_i  (pop[g]),
      .data_o (head[g]),
      .empty_o(empty[g]),
      .full_o (full[g])
    );

    assert_err_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_valid_o[g] |-> err_code_o[2*g +: 2] != 2'd0);
  end

  spi_arb_rr #(.N(NDEV), .IW(IW)) u_rr (
    .req_i (elig),
    .last_i(last_q),
    .gnt_o (pick_vec),
    .idx_o (pick_idx)
  );

  always_comb begin
    sel = '0;
    for (int d = 0; d < NDEV; d++) begin
      if (pick_vec[d]) sel = head[d];
    end
  end
  assign sel_op = op_e'(sel[W-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cur_dev_q    <= '0;
      cur_handle_q <= '0;
      cur_keep_q   <= 1'b0;
      last_q       <= IW'(NDEV - 1);
      lock_q       <= 1'b0;
      owner_q      <= '0;
      cs_hold_q    <= 1'b0;
      err_valid_q  <= '0;
      err_code_q   <= '0;
      acq_gnt_q    <= '0;
      done_q       <= '0;
    end else begin
      err_valid_q <= rej_arg | rej_st;
      for (int d = 0; d < NDEV; d++) begin
        err_code_q[2*d +: 2] <= rej_arg[d] ? ERR_ARG : (rej_st[d] ? ERR_STATE : ERR_NONE);
      end
      acq_gnt_q <= '0;
      done_q    <= '0;
      case (st_q)
        ST_IDLE: begin
          if (|pick_vec) begin
            last_q <= pick_idx;
            case (sel_op)
              OP_XFER: begin
                cur_dev_q    <= pick_idx;
                cur_handle_q <= sel[HW-1:0];
                cur_keep_q   <= sel[HW];
                st_q         <= ST_REQ;
              end
              OP_ACQ: begin
                lock_q    <= 1'b1;
                owner_q   <= pick_idx;
                acq_gnt_q <= pick_vec;
              end
              OP_REL: begin
                if (lock_q && owner_q == pick_idx) begin
                  lock_q    <= 1'b0;
                  cs_hold_q <= 1'b0;
                end
              end
              default: ;
            endcase
          end
        end
        ST_REQ: if (eng_gnt_i) st_q <= ST_RUN;
        ST_RUN: begin
          if (eng_done_i) begin
            st_q      <= ST_IDLE;
            done_q    <= NDEV'(1) << cur_dev_q;
            cs_hold_q <= cur_keep_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign eng_req_o     = (st_q == ST_REQ);
  assign eng_dev_o     = cur_dev_q;
  assign eng_handle_o  = cur_handle_q;
  assign eng_keep_cs_o = cur_keep_q;
  assign err_valid_o   = err_valid_q;
  assign err_code_o    = err_code_q;
  assign acq_gnt_o     = acq_gnt_q;
  assign done_o        = done_q;

  assert_single_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);
  assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_gnt_i |=> eng_req_o);
  assert_acq_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acq_gnt_o) |-> !eng_req_o && $onehot0(acq_gnt_o));
  assert_lock_defer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |-> (!lock_q || eng_dev_o == owner_q));
  assert_keep_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_keep_cs_o |-> lock_q && eng_dev_o == owner_q);
  assert_hold_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_hold_q |-> lock_q);
endmodule

// File: tb/spi_bus_arbiter_test.sv
`timescale 1ns/1ps
module spi_bus_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  req_valid = '0;
  logic [5:0]  req_op = '0;
  logic [23:0] req_handle = '0;
  logic [2:0]  req_keep = '0;
  logic [2:0]  req_poll = '0;
  logic        eng_gnt = 1'b0;
  logic        eng_done = 1'b0;
  logic [2:0]  req_ready, err_valid, acq_gnt, done, cs_n;
  logic [5:0]  err_code;
  logic        eng_req, eng_keep;
  logic [1:0]  eng_dev;
  logic [7:0]  eng_handle;

  spi_bus_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_handle_i(req_handle), .req_keep_cs_i(req_keep), .req_poll_i(req_poll),
    .err_valid_o(err_valid), .err_code_o(err_code), .acq_gnt_o(acq_gnt), .done_o(done),
    .eng_req_o(eng_req), .eng_gnt_i(eng_gnt), .eng_done_i(eng_done),
    .eng_dev_o(eng_dev), .eng_handle_o(eng_handle), .eng_keep_cs_o(eng_keep),
    .cs_n_o(cs_n)
  );

  int n_chk = 0;
  int n_err = 0;
  bit eng_en = 1'b1;
  int n_log = 0;
  int log_dev [64];
  int log_h [64];
  int log_keep [64];
  int done_total = 0;
  int done_cnt [3] = '{0, 0, 0};
  int acq_cnt [3] = '{0, 0, 0};
  int acq_snap [3] = '{0, 0, 0};

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // engine model: grant one cycle, run 3 cycles, pulse done
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && eng_en && eng_req) begin
        if (n_log < 64) begin
          log_dev[n_log]  = int'(eng_dev);
          log_h[n_log]    = int'(eng_handle);
          log_keep[n_log] = int'(eng_keep);
        end
        check(cs_n == ~(3'b001 << eng_dev), "R2 select at grant",
              int'(cs_n), int'(~(3'b001 << eng_dev)));
        n_log++;
        eng_gnt = 1'b1;
        @(negedge clk);
        eng_gnt = 1'b0;
        repeat (3) @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      for (int d = 0; d < 3; d++) begin
        if (done[d]) begin
          done_cnt[d]++;
          done_total++;
        end
        if (acq_gnt[d]) begin
          acq_cnt[d]++;
          acq_snap[d] = done_total;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic push(input int d, input logic [1:0] op, input logic [7:0] h,
                      input logic keep, input logic poll, output int code);
    @(negedge clk);
    req_op[2*d +: 2]     = op;
    req_handle[8*d +: 8] = h;
    req_keep[d]  = keep;
    req_poll[d]  = poll;
    req_valid[d] = 1'b1;
    while (!req_ready[d]) @(negedge clk);
    @(negedge clk);
    req_valid[d] = 1'b0;
    req_keep[d]  = 1'b0;
    req_poll[d]  = 1'b0;
    code = err_valid[d] ? int'(err_code[2*d +: 2]) : 0;
  endtask

  task automatic wait_done(input int target);
    for (int t = 0; t < 2000 && done_total < target; t++) @(negedge clk);
  endtask

  task automatic wait_acq(input int d, input int target);
    for (int t = 0; t < 2000 && acq_cnt[d] < target; t++) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cs_n == 3'b111, "R1 selects", int'(cs_n), 7);
    check(eng_req == 1'b0, "R1 engine request", int'(eng_req), 0);
    check(req_ready == 3'b111, "R1 ready", int'(req_ready), 7);
    check(err_valid == 3'b000 && acq_gnt == 3'b000, "R1 pulses", int'(err_valid), 0);
  endtask

  task automatic t_basic();
    int c, base;
    base = done_total;
    push(1, 2'd0, 8'h21, 1'b0, 1'b0, c);
    check(c == 0, "R10 accepted no error", c, 0);
    wait_done(base + 1);
    check(log_dev[n_log-1] == 1 && log_h[n_log-1] == 'h21, "R2 handle", log_h[n_log-1], 'h21);
    check(done_cnt[1] == 1, "R10 done pulse", done_cnt[1], 1);
    repeat (2) @(negedge clk);
    check(cs_n == 3'b111, "R2 select released", int'(cs_n), 7);
  endtask

  task automatic t_rr();
    int c, base, l0;
    int exp_h [4] = '{'h31, 'h33, 'h34, 'h32};
    eng_en = 1'b0;
    base = done_total;
    l0 = n_log;
    push(0, 2'd0, 8'h31, 1'b0, 1'b0, c);
    push(0, 2'd0, 8'h32, 1'b0, 1'b0, c);
    push(1, 2'd0, 8'h33, 1'b0, 1'b0, c);
    push(2, 2'd0, 8'h34, 1'b0, 1'b0, c);
    eng_en = 1'b1;
    wait_done(base + 4);
    for (int i = 0; i < 4; i++)
      check(log_h[l0+i] == exp_h[i], "R3 rotation order", log_h[l0+i], exp_h[i]);
  endtask

  task automatic t_fifo();
    int c, base, l0;
    eng_en = 1'b0;
    base = done_total;
    l0 = n_log;
    for (int i = 0; i < 5; i++) push(0, 2'd0, 8'(8'h41 + i), 1'b0, 1'b0, c);
    check(req_ready == 3'b110, "R4 full drops ready", int'(req_ready), 6);
    eng_en = 1'b1;
    wait_done(base + 5);
    for (int i = 0; i < 5; i++)
      check(log_h[l0+i] == 'h41 + i, "R4 queue order", log_h[l0+i], 'h41 + i);
    check(req_ready == 3'b111, "R4 ready restored", int'(req_ready), 7);
  endtask

  task automatic t_keep_nolock();
    int c, l0;
    l0 = n_log;
    push(2, 2'd0, 8'h51, 1'b1, 1'b0, c);
    check(c == 1, "R7 keep without lock", c, 1);
    repeat (12) @(negedge clk);
    check(n_log == l0, "R7 rejected not issued", n_log, l0);
    check(cs_n == 3'b111, "R7 selects idle", int'(cs_n), 7);
  endtask

  task automatic t_poll();
    int c, base, l0;
    eng_en = 1'b0;
    base = done_total;
    l0 = n_log;
    push(2, 2'd0, 8'h61, 1'b0, 1'b0, c);
    push(2, 2'd0, 8'h62, 1'b0, 1'b1, c);
    check(c == 2, "R8 polled while outstanding", c, 2);
    eng_en = 1'b1;
    wait_done(base + 1);
    repeat (12) @(negedge clk);
    check(n_log == l0 + 1 && log_h[l0] == 'h61, "R8 only first issued", n_log - l0, 1);
    push(2, 2'd0, 8'h63, 1'b0, 1'b1, c);
    check(c == 0, "R8 polled when clear", c, 0);
    wait_done(base + 2);
    check(log_h[n_log-1] == 'h63, "R8 polled issued", log_h[n_log-1], 'h63);
  endtask

  task automatic t_lock();
    int c, base;
    push(1, 2'd1, 8'h00, 1'b0, 1'b0, c);
    wait_acq(1, 1);
    check(acq_cnt[1] == 1, "R5 acquire granted", acq_cnt[1], 1);
    eng_en = 1'b0;
    base = done_total;
    push(0, 2'd0, 8'h71, 1'b0, 1'b0, c);
    push(1, 2'd0, 8'h72, 1'b1, 1'b0, c);
    check(c == 0, "R7 keep under lock", c, 0);
    eng_en = 1'b1;
    wait_done(base + 1);
    check(log_dev[n_log-1] == 1 && log_keep[n_log-1] == 1, "R6 owner first",
          log_dev[n_log-1], 1);
    repeat (12) @(negedge clk);
    check(cs_n == 3'b101, "R9 select held", int'(cs_n), 5);
    check(done_total == base + 1, "R6 other device deferred", done_total, base + 1);
    push(1, 2'd2, 8'h00, 1'b0, 1'b0, c);
    wait_done(base + 2);
    check(log_dev[n_log-1] == 0 && log_h[n_log-1] == 'h71, "R6 served after release",
          log_h[n_log-1], 'h71);
    repeat (2) @(negedge clk);
    check(cs_n == 3'b111, "R9 select released", int'(cs_n), 7);
  endtask

  task automatic t_drain();
    int c, base;
    eng_en = 1'b0;
    base = done_total;
    push(0, 2'd0, 8'h81, 1'b0, 1'b0, c);
    push(2, 2'd1, 8'h00, 1'b0, 1'b0, c);
    repeat (10) @(negedge clk);
    check(acq_cnt[2] == 0, "R5 acquire waits for engine", acq_cnt[2], 0);
    eng_en = 1'b1;
    wait_acq(2, 1);
    check(acq_snap[2] == base + 1, "R5 acquire after drain", acq_snap[2], base + 1);
    push(0, 2'd2, 8'h00, 1'b0, 1'b0, c);
    push(0, 2'd0, 8'h82, 1'b0, 1'b0, c);
    repeat (12) @(negedge clk);
    check(done_total == base + 1, "R6 foreign release ignored", done_total, base + 1);
    push(2, 2'd2, 8'h00, 1'b0, 1'b0, c);
    wait_done(base + 2);
    check(log_h[n_log-1] == 'h82, "R6 served after owner release", log_h[n_log-1], 'h82);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rr();
    t_fifo();
    t_keep_nolock();
    t_poll();
    t_lock();
    t_drain();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule